// File: doc/BRIEF.md
# Remote DMA Address Counter

This block sequences host-initiated transfers between a host data port and local buffer memory. Software writes a 16-bit start address and a 16-bit byte count one byte at a time, then issues a start with a chosen direction and transfer width. From then on, each transfer strobe from the data port is accepted. The block presents the current memory address, advances it, and reduces the remaining byte count. When the count is used up, it reports completion.

A byte-mode transfer moves one byte: the address advances by one and the count drops by one. A word-mode transfer advances the address by two and drops the count by two. An odd count ends on a final word transfer that takes the count from one to zero. The current address is always visible as two byte-wide readback ports. The block does not handle memory arbitration or the host bus cycle.

Control is a three-state machine:

- `ST_IDLE`: the state after reset.
- `ST_RUN`: a transfer is in progress.
- `ST_DONE`: the count has been exhausted.

The machine has these transitions:

- *launch*: from `ST_IDLE` or `ST_DONE` to `ST_RUN`, on a start with a non-zero count.
- *empty launch*: from `ST_IDLE` or `ST_DONE` to `ST_DONE`, on a start with a zero count.
- *finish*: from `ST_RUN` to `ST_DONE`, on the strobe that empties the count.
- *hold*: every other case keeps the present state.

Top module: `rdma_seq`

## Requirements
- R1: Writing with `prog_sel`=0 sets start-address bits 7:0, and writing with `prog_sel`=1 sets bits 15:8. Each write leaves the other byte unchanged.
- R2: Writing with `prog_sel`=2 sets byte-count bits 7:0, and writing with `prog_sel`=3 sets bits 15:8. Each write leaves the other byte unchanged.
- R3: A start in `ST_IDLE` or `ST_DONE` does the following:
  - copies the start address into the current address;
  - copies the byte count into the remaining count;
  - latches `word_mode` and `dir_write`;
  - clears `done_flag`.

  A start while `busy` is high is ignored.
- R4: While `busy` is high, a strobe drives `xfer_fire` high in the same cycle, with `mem_addr` showing the current address. The address then advances by 1 in byte mode or by 2 in word mode.
- R5: Each accepted strobe lowers the remaining count by 1 in byte mode or by 2 in word mode. In word mode a remaining count of 1 goes to 0.
- R6: The current address wraps modulo 65536. For example, 0xFFFE + 2 = 0x0000.
- R7: When the remaining count reaches zero, the block does the following:
  - `busy` falls;
  - `done_pulse` is high for exactly the one cycle after the final strobe;
  - `done_flag` goes high and stays high until the next accepted start.
- R8: While `busy` is low, strobes are ignored: `xfer_fire` stays low and the current address is unchanged.
- R9: A start with a zero byte count makes no transfers. `done_pulse` is high in the cycle after the start, and `done_flag` is set.
- R10: After reset the block is in `ST_IDLE`, with current address 0, all programmed bytes 0, and `busy`, `done_flag` and `done_pulse` low.
- R11: `cur_lo` and `cur_hi` show bits 7:0 and bits 15:8 of the current address at all times.
- R12: `xfer_write` shows the direction latched at the last accepted start: 1 means memory write, 0 means memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program-register write enable |
| prog_sel | input | 2 | Register select: 0 addr lo, 1 addr hi, 2 count lo, 3 count hi |
| prog_data | input | 8 | Program write data |
| start | input | 1 | Start request |
| dir_write | input | 1 | Direction for the next start (1 = write memory) |
| word_mode | input | 1 | Width for the next start (1 = word) |
| xfer_stb | input | 1 | Transfer strobe from the data port |
| xfer_fire | output | 1 | Strobe accepted this cycle |
| xfer_write | output | 1 | Latched direction |
| mem_addr | output | 16 | Current memory address |
| cur_lo | output | 8 | Current address bits 7:0 |
| cur_hi | output | 8 | Current address bits 15:8 |
| busy | output | 1 | Transfer in progress |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The counters have several failure modes, and each shows at the ports within a short time:

- A wrong address step or a missed wrap shows on `mem_addr` at the very next accepted strobe, so the scoreboard, which predicts every address, sees it within one transfer.
- A wrong count step changes how many strobes are accepted. It shows as an unexpected `xfer_fire`, or as `done_pulse` arriving one transfer early or late.
- A state machine that takes a start while busy, or that accepts a strobe while idle, shows on `xfer_fire` and on the readback address in the next cycle.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rdma_state_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_ADDR_LO = 2'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR_HI = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CNT_LO  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CNT_HI  = 2'd3;
endpackage

// File: rtl/rdma_progregs.sv
module rdma_progregs
    import rdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    output logic [AW-1:0]    start_addr,
    output logic [CW-1:0]    byte_cnt
);
    localparam int NB = 2;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_addr[8*b +: 8] <= '0;
                    byte_cnt[8*b +: 8]   <= '0;
                end else if (we) begin
                    if (sel == SEL_W'(b))
                        start_addr[8*b +: 8] <= wdata;           // R1
                    if (sel == SEL_W'(2 + b))
                        byte_cnt[8*b +: 8] <= wdata;             // R2
                end
            end
        end
    endgenerate

    AST_WRITE_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_ADDR_LO) |=> start_addr[15:8] == $past(start_addr[15:8])); // R1
endmodule

// File: rtl/rdma_ctr.sv
module rdma_ctr #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          step_en,
    input  logic          word,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] rem,
    output logic          last
);
    logic [CW-1:0] step;

    always_comb begin
        step = word ? CW'(2) : CW'(1);
        last = (rem <= step);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            rem  <= '0;
        end else if (load) begin
            addr <= load_addr;
            rem  <= load_cnt;
        end else if (step_en) begin
            addr <= addr + AW'(step);                 // R4 R6
            rem  <= last ? '0 : rem - step;           // R5
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && rem != '0) |=> rem < $past(rem)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |=> (addr - $past(addr)) == ($past(word) ? AW'(2) : AW'(1))); // R4
endmodule

// File: rtl/rdma_fsm.sv
module rdma_fsm
    import rdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic stb,
    input  logic last,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done_flag,
    output logic done_pulse
);
    rdma_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) nxt = cnt_zero ? ST_DONE : ST_RUN;
            ST_RUN:           if (stb && last) nxt = ST_DONE;
            default:          nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load      = start && (state != ST_RUN);      // R3
        step_en   = stb && (state == ST_RUN);        // R8
        busy      = (state == ST_RUN);
        done_flag = (state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done_pulse <= 1'b0;
        else        done_pulse <= (load && cnt_zero) || (step_en && last); // R7 R9
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse || $past(load)); // R7
    AST_PULSE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> done_flag); // R7
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
    import rdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic [SEL_W-1:0] prog_sel,
    input  logic [7:0]       prog_data,
    input  logic             start,
    input  logic             dir_write,
    input  logic             word_mode,
    input  logic             xfer_stb,
    output logic             xfer_fire,
    output logic             xfer_write,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       cur_lo,
    output logic [7:0]       cur_hi,
    output logic             busy,
    output logic             done_pulse,
    output logic             done_flag
);
    logic [AW-1:0] start_addr;
    logic [CW-1:0] byte_cnt, rem;
    logic          load, last, word_q;

    rdma_progregs #(.AW(AW), .CW(CW)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(prog_we), .sel(prog_sel),
        .wdata(prog_data), .start_addr(start_addr), .byte_cnt(byte_cnt)
    );

    rdma_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_zero(byte_cnt == '0),
        .stb(xfer_stb), .last(last), .load(load), .step_en(xfer_fire),
        .busy(busy), .done_flag(done_flag), .done_pulse(done_pulse)
    );

    rdma_ctr #(.AW(AW), .CW(CW)) i_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(start_addr),
        .load_cnt(byte_cnt), .step_en(xfer_fire), .word(word_q),
        .addr(mem_addr), .rem(rem), .last(last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q     <= 1'b0;
            xfer_write <= 1'b0;
        end else if (load) begin
            word_q     <= word_mode;                 // R3
            xfer_write <= dir_write;                 // R12
        end
    end

    assign cur_lo = mem_addr[7:0];                   // R11
    assign cur_hi = mem_addr[15:8];

    AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_fire); // R8
    AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(mem_addr)); // R8
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> rem == '0); // R7
endmodule

// File: tb/test_rdma_seq.sv
module test_rdma_seq;
    logic clk = 0, rst_n = 0;
    logic prog_we = 0, start = 0, dir_write = 0, word_mode = 0, xfer_stb = 0;
    logic [1:0] prog_sel = 0;
    logic [7:0] prog_data = 0;
    logic xfer_fire, xfer_write, busy, done_pulse, done_flag;
    logic [15:0] mem_addr;
    logic [7:0] cur_lo, cur_hi;

    int n_chk = 0, n_fail = 0;
    logic [16:0] exp_q[$];

    always #2 clk = ~clk;

    rdma_seq i_rdma_seq (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare every accepted strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n && xfer_fire) begin
            if (exp_q.size() == 0) chk(0, "R8 unexpected fire", {xfer_write, mem_addr}, 0);
            else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                chk({xfer_write, mem_addr} == e, "R4/R6/R12 strobe", {xfer_write, mem_addr}, e);
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #1 prog_we = 1; prog_sel = s; prog_data = d;
        @(posedge clk); #1 prog_we = 0;
    endtask

    task automatic go(input bit w, input bit d);
        @(posedge clk); #1 start = 1; word_mode = w; dir_write = d;
        @(posedge clk); #1 start = 0;
    endtask

    // one strobe; expect = 1 pushes the predicted {dir, addr}
    task automatic stb(input bit expect_fire, input logic [16:0] e);
        @(posedge clk); #1 xfer_stb = 1;
        if (expect_fire) exp_q.push_back(e);
        @(posedge clk); #1 xfer_stb = 0;
    endtask

    initial begin
        #400000;
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!busy && !done_flag && !done_pulse && mem_addr == 0, "R10 reset", mem_addr, 0);

        // R8: strobe while idle
        stb(0, 0);
        @(negedge clk); chk(mem_addr == 0, "R8 idle strobe addr", mem_addr, 0);

        // byte mode read, 0x1234 count 5
        wr(0, 8'h34); wr(1, 8'h12); wr(2, 8'h05); wr(3, 8'h00);
        go(0, 0);
        @(negedge clk); chk(busy && {cur_hi, cur_lo} == 16'h1234, "R3 R11 load", {cur_hi, cur_lo}, 16'h1234);
        for (int i = 0; i < 5; i++) stb(1, {1'b0, 16'h1234 + 16'(i)});
        @(negedge clk);
        chk(done_pulse, "R7 pulse", done_pulse, 1);
        chk(done_flag && !busy, "R7 flag", done_flag, 1);
        chk(mem_addr == 16'h1239, "R4 final addr", mem_addr, 16'h1239);
        @(negedge clk); chk(!done_pulse, "R7 pulse one cycle", done_pulse, 0);
        stb(0, 0);
        @(negedge clk); chk(mem_addr == 16'h1239 && done_flag, "R8 done strobe", mem_addr, 16'h1239);

        // word mode write, wrap, odd count 5 -> 3 -> 1 -> 0
        wr(0, 8'hFC); wr(1, 8'hFF);
        go(1, 1);
        @(negedge clk); chk(!done_flag, "R3 flag clear", done_flag, 0);
        stb(1, {1'b1, 16'hFFFC});
        stb(1, {1'b1, 16'hFFFE});
        @(negedge clk); chk(mem_addr == 16'h0000 && busy, "R6 wrap", mem_addr, 0);
        stb(1, {1'b1, 16'h0000});
        @(negedge clk);
        chk(done_pulse && !busy, "R5 odd word end", busy, 0);
        chk(mem_addr == 16'h0002, "R5 final addr", mem_addr, 2);

        // R9: zero count
        wr(2, 8'h00);
        go(0, 0);
        @(negedge clk); chk(done_pulse && done_flag && !busy, "R9 zero count", done_pulse, 1);
        stb(0, 0);
        @(negedge clk); chk(mem_addr == 16'hFFFC, "R9 no transfer", mem_addr, 16'hFFFC);

        // R3: start while busy ignored
        wr(0, 8'h00); wr(1, 8'h01); wr(2, 8'h04);
        go(1, 0);
        stb(1, {1'b0, 16'h0100});
        wr(0, 8'hAB); wr(1, 8'h50); wr(2, 8'h03);
        go(0, 1);
        @(negedge clk); chk(mem_addr == 16'h0102 && busy && !xfer_write, "R3 busy start ignored", mem_addr, 16'h0102);
        stb(1, {1'b0, 16'h0102});
        @(negedge clk); chk(done_flag && mem_addr == 16'h0104, "R3 R5 word count", mem_addr, 16'h0104);

        // R1/R2: partial byte writes keep the other byte
        wr(1, 8'h77); wr(2, 8'h01);
        go(0, 1);
        @(negedge clk); chk(mem_addr == 16'h77AB, "R1 hi only", mem_addr, 16'h77AB);
        stb(1, {1'b1, 16'h77AB});
        @(negedge clk); chk(done_pulse && mem_addr == 16'h77AC, "R2 lo count", mem_addr, 16'h77AC);

        wr(3, 8'h01);   // count = 0x0101
        go(0, 0);
        for (int i = 0; i < 257; i++) stb(1, {1'b0, 16'h77AB + 16'(i)});
        @(negedge clk); chk(done_pulse && mem_addr == 16'h78AC, "R2 hi count", mem_addr, 16'h78AC);

        @(negedge clk);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule